// File: doc/BRIEF.md
# Manchester Receive Bit Checker

This block watches a demodulated serial line, already synchronous to the system clock, and judges whether it carries valid Manchester-coded data. Each cycle it counts clock cycles since the last change of the line. When the line changes, the elapsed count is sorted into a half-bit window, a full-bit window, or neither. All four window limits arrive as input ports.

After leaving start-up on the first edge, the block enters a bit-check phase. There it expects a preamble of zeros, which shows up as a string of half-bit intervals. A full-bit interval that ends with the line high marks a start bit, and the block moves to receiving. In receiving it follows the bit-centre edges, rebuilds the data bits and packs them into bytes, and delivers each complete byte with a one-cycle strobe.

Any interval outside both windows is an error. So is a gap that outlasts the full-bit limit, and so is a bit cell that lacks its centre edge. On an error the block pulses an interrupt, records which kind of error it was, throws away the partial byte and returns to start-up. A restart input forces start-up from outside.

Top module: `manchester_bit_checker`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block goes to start-up (`mode` = 00) and holds `byte_valid` = 0, `err_irq` = 0 and `err_kind` = 00.
- R2: An edge interval is the number of clock edges from the edge that first sees one line change to the edge that first sees the next change. It is half-bit if `lim_short_min` <= interval <= `lim_short_max`; this test is made first. Otherwise it is full-bit if `lim_long_min` <= interval <= `lim_long_max`. Any other interval seen in bit-check or receiving is a timing error, with `err_kind` = 01.
- R3: In bit-check or receiving, once the count since the last edge exceeds `lim_long_max` with no edge seen, a timing error (01) is raised. This works for every `lim_long_max`, including the largest value the limit width can hold; the internal counter saturates rather than wraps.
- R4: In receiving, a full-bit interval that follows a boundary edge means the bit centre had no edge. This is a logical error, with `err_kind` = 10.
- R5: Every error gives a single-cycle `err_irq` pulse, and `mode` returns to start-up on the same clock edge. `err_kind` keeps the code until the next error, a restart or a reset.
- R6: Mode codes are 00 start-up, 01 bit-check and 10 receiving. The first edge seen in start-up moves the block to bit-check and clears its half-bit count. In bit-check, a full-bit interval that ends with the line high, after at least `PREAMBLE_EDGES` half-bit intervals, moves the block to receiving. Any other full-bit interval in bit-check clears the count and raises no error.
- R7: In receiving, the bit value is the line level after a bit-centre edge, so 1 means a rising edge at the centre. The start bit's edge is a centre edge. After a centre edge, a half-bit interval marks a boundary edge and a full-bit interval marks the next centre. After a boundary edge, a half-bit interval marks a centre.
- R8: The decoded bits after the start bit are packed into `BYTE_W`-bit bytes, most significant bit first. Each byte is shown on `byte_data` with a one-cycle `byte_valid` pulse.
- R9: An error discards any partly assembled byte, so no `byte_valid` is given for it. The next frame's first byte starts from an empty shift register.
- R10: A clock edge with `restart` high forces start-up. It clears `err_kind` to 00 and drops the partial byte, without an `err_irq`.
- R11: All outputs change on the clock edge that first samples the changed line level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| restart | input | 1 | Force start-up, clear error code and partial byte |
| rx_line | input | 1 | Demodulated data line, synchronous to `clk` |
| lim_short_min | input | LIM_W | Lower bound of half-bit window, in cycles |
| lim_short_max | input | LIM_W | Upper bound of half-bit window, in cycles |
| lim_long_min | input | LIM_W | Lower bound of full-bit window, in cycles |
| lim_long_max | input | LIM_W | Upper bound of full-bit window; also the gap timeout |
| mode | output | 2 | 00 start-up, 01 bit-check, 10 receiving |
| byte_data | output | BYTE_W | Last completed byte |
| byte_valid | output | 1 | One-cycle strobe for `byte_data` |
| err_irq | output | 1 | One-cycle error interrupt |
| err_kind | output | 2 | 00 none, 01 timing, 10 logical; held |

## Verification
The logical error is the hardest case to reach from the ports. It needs a frame that has already locked onto a start bit and then has a boundary edge, followed by a gap long enough to fall in the full-bit window. The stimulus builds that line waveform by hand, half-cell by half-cell. Gap detection at the largest full-bit limit is reached by raising `lim_long_max` to its maximum and then leaving the line idle for far longer than the limit. A behavioural model in the bench tracks elapsed cycles as plain integers and is compared with every output on every clock.

// File: rtl/mbc_pkg.sv
// Package: shared encodings for the Manchester receive bit checker.
// Assumes: nothing; consumed by every module of the block.
package mbc_pkg;

    // Operating phase reported on the mode output.
    typedef enum logic [1:0] {
        MODE_STARTUP  = 2'b00,
        MODE_BITCHECK = 2'b01,
        MODE_RECEIVE  = 2'b10
    } mode_t;

    // Error code reported on err_kind.
    typedef enum logic [1:0] {
        ERR_NONE   = 2'b00,
        ERR_TIMING = 2'b01,
        ERR_LOGIC  = 2'b10
    } err_t;

    // Classification of one edge-to-edge interval.
    typedef enum logic [1:0] {
        IVL_SHORT = 2'b00,
        IVL_LONG  = 2'b01,
        IVL_BAD   = 2'b10
    } ivl_t;

endpackage

// File: rtl/mbc_edge_timer.sv
// Module: mbc_edge_timer
// Finds changes on the data line and measures the cycles between them.
// The measured interval is sorted into half-bit, full-bit or invalid,
// and the module flags when the current gap has passed the full-bit limit.
// Assumes: rx_line is already synchronous to clk. The counter is one bit
// wider than the limits, so it can pass any limit before it saturates.
module mbc_edge_timer #(
    parameter int LIM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_line,
    input  logic [LIM_W-1:0]  lim_short_min,
    input  logic [LIM_W-1:0]  lim_short_max,
    input  logic [LIM_W-1:0]  lim_long_min,
    input  logic [LIM_W-1:0]  lim_long_max,
    output logic              edge_seen,
    output mbc_pkg::ivl_t     ivl_class,
    output logic              overdue
);
    import mbc_pkg::*;

    localparam int CNT_W = LIM_W + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic             prev_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] s_min, s_max, l_min, l_max;

    assign s_min = {1'b0, lim_short_min};
    assign s_max = {1'b0, lim_short_max};
    assign l_min = {1'b0, lim_long_min};
    assign l_max = {1'b0, lim_long_max};

    assign edge_seen = rx_line ^ prev_q;
    assign overdue   = (cnt_q > l_max);

    // Keep the previous line level; during reset it follows the line, so release gives no false edge.
    always_ff @(posedge clk) begin
        prev_q <= rx_line;
    end

    // Count the cycles since the last edge, saturating at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (edge_seen) begin
            cnt_q <= CNT_W'(1);
        end else if (cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    // Sort the interval that ends at this edge; the half-bit window is tested first.
    always_comb begin
        if (cnt_q >= s_min && cnt_q <= s_max) begin
            ivl_class = IVL_SHORT;
        end else if (cnt_q >= l_min && cnt_q <= l_max) begin
            ivl_class = IVL_LONG;
        end else begin
            ivl_class = IVL_BAD;
        end
    end

    // A saturated counter must never count down or wrap to a small value.
    assert_count_saturates_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !edge_seen) |=> (cnt_q == CNT_MAX));

endmodule

// File: rtl/mbc_frame_fsm.sv
// Module: mbc_frame_fsm
// Steps through start-up, bit-check and receiving. In bit-check it counts
// preamble half-bit intervals and waits for the start bit. In receiving it
// follows bit-centre edges to pick out data bits. It raises timing and
// logical errors and keeps the last error code.
// Assumes: edge_seen, ivl_class and overdue come from mbc_edge_timer in the
// same cycle; line_now is the level after the edge.
module mbc_frame_fsm #(
    parameter int PREAMBLE_EDGES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              edge_seen,
    input  logic              line_now,
    input  mbc_pkg::ivl_t     ivl_class,
    input  logic              overdue,
    output mbc_pkg::mode_t    mode,
    output logic              bit_strobe,
    output logic              asm_clear,
    output logic              err_irq,
    output mbc_pkg::err_t     err_kind
);
    import mbc_pkg::*;

    localparam int PRE_W = $clog2(PREAMBLE_EDGES + 1);
    localparam logic [PRE_W-1:0] PRE_FULL = PRE_W'(PREAMBLE_EDGES);

    mode_t            mode_q, mode_d;
    logic             centre_q, centre_d;
    logic [PRE_W-1:0] pre_q, pre_d;
    logic             irq_q;
    err_t             kind_q;
    logic             err_hit;
    err_t             err_code;
    logic             rx_enter;

    // Work out the next phase, the bit strobe and any error for this cycle.
    always_comb begin
        mode_d     = mode_q;
        centre_d   = centre_q;
        pre_d      = pre_q;
        err_hit    = 1'b0;
        err_code   = ERR_NONE;
        bit_strobe = 1'b0;
        rx_enter   = 1'b0;
        if (restart) begin
            mode_d = MODE_STARTUP;
        end else begin
            unique case (mode_q)
                MODE_STARTUP: begin
                    if (edge_seen) begin
                        mode_d = MODE_BITCHECK;
                        pre_d  = '0;
                    end
                end
                MODE_BITCHECK: begin
                    if (edge_seen) begin
                        case (ivl_class)
                            IVL_SHORT: begin
                                if (pre_q != PRE_FULL) pre_d = pre_q + PRE_W'(1);
                            end
                            IVL_LONG: begin
                                if (pre_q == PRE_FULL && line_now) begin
                                    mode_d   = MODE_RECEIVE;
                                    centre_d = 1'b1;
                                    rx_enter = 1'b1;
                                end else begin
                                    pre_d = '0;
                                end
                            end
                            default: begin
                                err_hit  = 1'b1;
                                err_code = ERR_TIMING;
                            end
                        endcase
                    end else if (overdue) begin
                        err_hit  = 1'b1;
                        err_code = ERR_TIMING;
                    end
                end
                MODE_RECEIVE: begin
                    if (edge_seen) begin
                        case (ivl_class)
                            IVL_SHORT: begin
                                if (centre_q) begin
                                    centre_d = 1'b0;
                                end else begin
                                    centre_d   = 1'b1;
                                    bit_strobe = 1'b1;
                                end
                            end
                            IVL_LONG: begin
                                if (centre_q) begin
                                    bit_strobe = 1'b1;
                                end else begin
                                    err_hit  = 1'b1;
                                    err_code = ERR_LOGIC;
                                end
                            end
                            default: begin
                                err_hit  = 1'b1;
                                err_code = ERR_TIMING;
                            end
                        endcase
                    end else if (overdue) begin
                        err_hit  = 1'b1;
                        err_code = ERR_TIMING;
                    end
                end
                default: mode_d = MODE_STARTUP;
            endcase
            if (err_hit) mode_d = MODE_STARTUP;
        end
    end

    // Register the phase, the centre tracker and the preamble count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= MODE_STARTUP;
            centre_q <= 1'b0;
            pre_q    <= '0;
        end else begin
            mode_q   <= mode_d;
            centre_q <= centre_d;
            pre_q    <= pre_d;
        end
    end

    // Register the interrupt pulse and hold the last error code.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q  <= 1'b0;
            kind_q <= ERR_NONE;
        end else begin
            irq_q <= err_hit;
            if (restart) begin
                kind_q <= ERR_NONE;
            end else if (err_hit) begin
                kind_q <= err_code;
            end
        end
    end

    assign mode      = mode_q;
    assign err_irq   = irq_q;
    assign err_kind  = kind_q;
    assign asm_clear = restart | err_hit | rx_enter;

    // An interrupt pulse always comes with a return to start-up.
    assert_irq_startup_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (mode == MODE_STARTUP));

    // The interrupt lasts one cycle; start-up never raises another at once.
    assert_irq_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |=> !err_irq);

    // A missing bit centre can only be found while receiving.
    assert_logic_err_in_receive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_irq && err_kind == ERR_LOGIC) |-> ($past(mode) == MODE_RECEIVE));

    // Receiving is only entered from bit-check.
    assert_receive_from_bitcheck_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RECEIVE && $past(mode) != MODE_RECEIVE) |-> ($past(mode) == MODE_BITCHECK));

    // A restart lands in start-up with the error code cleared and no interrupt.
    assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (mode == MODE_STARTUP && err_kind == ERR_NONE && !err_irq));

endmodule

// File: rtl/mbc_byte_asm.sv
// Module: mbc_byte_asm
// Shifts decoded bits in, most significant first, and shows each full byte
// with a one-cycle valid strobe.
// Assumes: clear and bit_strobe are never high together. Clear drops any
// bits collected so far.
module mbc_byte_asm #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              bit_strobe,
    input  logic              bit_val,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid
);
    localparam int BC_W = $clog2(BYTE_W);
    localparam logic [BC_W-1:0] LAST_BIT = BC_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shift_q;
    logic [BC_W-1:0]   nbits_q;
    logic [BYTE_W-1:0] shift_next;
    logic [BYTE_W-1:0] data_q;
    logic              valid_q;

    assign shift_next = {shift_q[BYTE_W-2:0], bit_val};

    // Collect bits and release a byte once the last bit arrives.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            nbits_q <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (clear) begin
                nbits_q <= '0;
            end else if (bit_strobe) begin
                shift_q <= shift_next;
                if (nbits_q == LAST_BIT) begin
                    data_q  <= shift_next;
                    valid_q <= 1'b1;
                    nbits_q <= '0;
                end else begin
                    nbits_q <= nbits_q + BC_W'(1);
                end
            end
        end
    end

    assign byte_data  = data_q;
    assign byte_valid = valid_q;

    // A byte takes several edges to build, so two strobes can never touch.
    assert_byte_strobe_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

endmodule

// File: rtl/manchester_bit_checker.sv
// Module: manchester_bit_checker (top)
// Checks and decodes a Manchester data line using programmable half-bit and
// full-bit timing windows. It hands out error-free bytes and reports timing
// and logical errors.
// Assumes: rx_line is synchronous to clk; the limits stay fixed during a frame.
module manchester_bit_checker #(
    parameter int LIM_W          = 8,
    parameter int BYTE_W         = 8,
    parameter int PREAMBLE_EDGES = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              rx_line,
    input  logic [LIM_W-1:0]  lim_short_min,
    input  logic [LIM_W-1:0]  lim_short_max,
    input  logic [LIM_W-1:0]  lim_long_min,
    input  logic [LIM_W-1:0]  lim_long_max,
    output logic [1:0]        mode,
    output logic [BYTE_W-1:0] byte_data,
    output logic              byte_valid,
    output logic              err_irq,
    output logic [1:0]        err_kind
);
    import mbc_pkg::*;

    logic  edge_seen;
    ivl_t  ivl_class;
    logic  overdue;
    mode_t mode_w;
    err_t  kind_w;
    logic  bit_strobe;
    logic  asm_clear;

    mbc_edge_timer #(.LIM_W(LIM_W)) u_timer (
        .clk           (clk),
        .rst_n         (rst_n),
        .rx_line       (rx_line),
        .lim_short_min (lim_short_min),
        .lim_short_max (lim_short_max),
        .lim_long_min  (lim_long_min),
        .lim_long_max  (lim_long_max),
        .edge_seen     (edge_seen),
        .ivl_class     (ivl_class),
        .overdue       (overdue)
    );

    mbc_frame_fsm #(.PREAMBLE_EDGES(PREAMBLE_EDGES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (restart),
        .edge_seen  (edge_seen),
        .line_now   (rx_line),
        .ivl_class  (ivl_class),
        .overdue    (overdue),
        .mode       (mode_w),
        .bit_strobe (bit_strobe),
        .asm_clear  (asm_clear),
        .err_irq    (err_irq),
        .err_kind   (kind_w)
    );

    mbc_byte_asm #(.BYTE_W(BYTE_W)) u_asm (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (asm_clear),
        .bit_strobe (bit_strobe),
        .bit_val    (rx_line),
        .byte_data  (byte_data),
        .byte_valid (byte_valid)
    );

    assign mode     = mode_w;
    assign err_kind = kind_w;

    // A byte is never released in the same cycle as an error.
    assert_no_byte_on_error_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> !byte_valid);

endmodule

// File: tb/manchester_bit_checker_test.sv
`timescale 1ns/1ps
module manchester_bit_checker_test;

    localparam int LW = 8;
    localparam int BW = 8;
    localparam int PRE = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          restart = 1'b0;
    logic          rx_line = 1'b0;
    logic [LW-1:0] smin = 8'd8, smax = 8'd12, lmin = 8'd16, lmax = 8'd24;
    logic [1:0]    mode;
    logic [BW-1:0] byte_data;
    logic          byte_valid, err_irq;
    logic [1:0]    err_kind;

    int checks = 0, fails = 0;
    int bytes_seen = 0, irq_seen = 0;
    int H = 10;
    bit finished = 0;
    logic [7:0] exp_q[$];

    always #4 clk = ~clk;

    manchester_bit_checker #(.LIM_W(LW), .BYTE_W(BW), .PREAMBLE_EDGES(PRE)) uut (
        .clk(clk), .rst_n(rst_n), .restart(restart), .rx_line(rx_line),
        .lim_short_min(smin), .lim_short_max(smax),
        .lim_long_min(lmin), .lim_long_max(lmax),
        .mode(mode), .byte_data(byte_data), .byte_valid(byte_valid),
        .err_irq(err_irq), .err_kind(err_kind)
    );

    // Behavioural reference: elapsed time kept as plain integers
    int m_mode = 0, m_kind = 0, m_pre = 0, m_bits = 0, ecode = 0;
    bit m_irq = 0, m_bv = 0, m_centre = 0, m_prev = 0, m_edge = 0, live = 0;
    logic [7:0] m_shift = 0, m_data = 0;
    int cyc = 0, last_edge = 0, gap = 0;

    function automatic bit in_short(int g);
        return g >= int'(smin) && g <= int'(smax);
    endfunction
    function automatic bit in_long(int g);
        return g >= int'(lmin) && g <= int'(lmax);
    endfunction

    always @(posedge clk) begin
        cyc = cyc + 1;
        live = 1;
        if (!rst_n) begin
            m_mode = 0; m_kind = 0; m_irq = 0; m_bv = 0; m_bits = 0; m_pre = 0;
            m_centre = 0; m_prev = rx_line; last_edge = cyc;
        end else begin
            m_edge = (rx_line != m_prev);
            m_prev = rx_line;
            gap = cyc - last_edge;
            m_irq = 0; m_bv = 0; ecode = 0;
            if (restart) begin
                m_mode = 0; m_kind = 0; m_bits = 0;
            end else if (m_mode == 0) begin
                if (m_edge) begin m_mode = 1; m_pre = 0; end
            end else if (m_mode == 1) begin
                if (m_edge) begin
                    if (in_short(gap)) begin
                        if (m_pre < PRE) m_pre = m_pre + 1;
                    end else if (in_long(gap)) begin
                        if (m_pre >= PRE && rx_line) begin m_mode = 2; m_centre = 1; m_bits = 0; end
                        else m_pre = 0;
                    end else ecode = 1;
                end else if (gap > int'(lmax)) ecode = 1;
            end else begin
                if (m_edge) begin
                    if (in_short(gap)) begin
                        if (m_centre) m_centre = 0;
                        else begin m_centre = 1; push_bit(rx_line); end
                    end else if (in_long(gap)) begin
                        if (m_centre) push_bit(rx_line);
                        else ecode = 2;
                    end else ecode = 1;
                end else if (gap > int'(lmax)) ecode = 1;
            end
            if (ecode != 0) begin
                m_irq = 1; m_kind = ecode; m_mode = 0; m_bits = 0;
            end
            if (m_edge) last_edge = cyc;
        end
    end

    task automatic push_bit(input logic b);
        m_shift = {m_shift[6:0], b};
        m_bits = m_bits + 1;
        if (m_bits == 8) begin m_bv = 1; m_data = m_shift; m_bits = 0; end
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Compare every output against the reference away from the active edge
    always @(negedge clk) begin
        if (live && !finished) begin
            check(int'(mode) == m_mode, "R6 mode", int'(mode), m_mode);
            check(err_irq == m_irq, "R5 err_irq", int'(err_irq), int'(m_irq));
            check(int'(err_kind) == m_kind, "R5 err_kind", int'(err_kind), m_kind);
            check(byte_valid == m_bv, "R8 R11 byte_valid", int'(byte_valid), int'(m_bv));
            if (byte_valid && m_bv)
                check(byte_data == m_data, "R8 byte_data", int'(byte_data), int'(m_data));
            if (err_irq) irq_seen = irq_seen + 1;
            if (byte_valid) begin
                bytes_seen = bytes_seen + 1;
                if (exp_q.size() == 0) check(0, "R7 unexpected byte", int'(byte_data), 0);
                else check(byte_data == exp_q.pop_front(), "R7 decoded byte", int'(byte_data), -1);
            end
        end
    end

    task automatic hold(input logic lvl, input int n);
        rx_line = lvl;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(input logic b);
        hold(~b, H);
        hold(b, H);
    endtask

    task automatic preamble_start(input int zeros);
        for (int i = 0; i < zeros; i++) send_bit(1'b0);
        send_bit(1'b1);
    endtask

    task automatic send_byte(input logic [7:0] v, input bit expect_it);
        if (expect_it) exp_q.push_back(v);
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic finish_report();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks = checks + 1;
        fails = fails + 1;
        $display("FAIL watchdog: actual hung expected done");
        finish_report();
    end

    int b0, i0;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(mode == 2'b00, "R1 mode", int'(mode), 0);
        check(!byte_valid && !err_irq, "R1 strobes", int'({byte_valid, err_irq}), 0);
        check(err_kind == 2'b00, "R1 err_kind", int'(err_kind), 0);
        rst_n = 1'b1;
        hold(1'b0, 20);

        // S1: nominal frame, two bytes, then idle gap timeout (R3)
        b0 = bytes_seen; i0 = irq_seen;
        preamble_start(8);
        send_byte(8'hA5, 1); send_byte(8'h3C, 1);
        hold(1'b0, 60);
        check(bytes_seen - b0 == 2, "R8 bytes in frame", bytes_seen - b0, 2);
        check(irq_seen - i0 == 1 && err_kind == 2'b01, "R3 idle timeout", int'(err_kind), 1);

        // S2/S3: window edges, half-bit at min and at max (R2)
        H = 8; b0 = bytes_seen;
        preamble_start(8); send_byte(8'h82, 1); hold(1'b0, 60);
        check(bytes_seen - b0 == 1, "R2 lower window edge", bytes_seen - b0, 1);
        H = 12; b0 = bytes_seen;
        preamble_start(8); send_byte(8'h5A, 1); hold(1'b0, 60);
        check(bytes_seen - b0 == 1, "R2 upper window edge", bytes_seen - b0, 1);
        H = 10;

        // S4: interval between the windows during bit-check (R2)
        i0 = irq_seen;
        hold(1'b1, 10); hold(1'b0, 10); hold(1'b1, 14); hold(1'b0, 40);
        check(irq_seen - i0 == 1 && err_kind == 2'b01, "R2 gap interval error", int'(err_kind), 1);

        // S5: missing centre edge, partial byte dropped, then recovery (R4, R9)
        b0 = bytes_seen; i0 = irq_seen;
        preamble_start(8);
        send_bit(1'b1); send_bit(1'b0);
        hold(1'b1, 2 * H); hold(1'b0, 60);
        check(irq_seen - i0 == 1 && err_kind == 2'b10, "R4 logical error", int'(err_kind), 2);
        check(bytes_seen == b0, "R9 partial byte dropped", bytes_seen - b0, 0);
        preamble_start(8); send_byte(8'hC6, 1); hold(1'b0, 60);
        check(bytes_seen - b0 == 1, "R9 clean next byte", bytes_seen - b0, 1);

        // S6: early start bit restarts the preamble count (R6)
        b0 = bytes_seen; i0 = irq_seen;
        preamble_start(2);
        preamble_start(8); send_byte(8'h1E, 1); hold(1'b0, 60);
        check(bytes_seen - b0 == 1 && irq_seen - i0 == 1, "R6 short preamble ignored", bytes_seen - b0, 1);

        // S7: restart in the middle of a byte (R10)
        b0 = bytes_seen; i0 = irq_seen;
        preamble_start(8);
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b0); send_bit(1'b0);
        restart = 1'b1; @(negedge clk); restart = 1'b0;
        check(mode == 2'b00 && err_kind == 2'b00, "R10 restart", int'({mode, err_kind}), 0);
        hold(rx_line, 60);
        check(irq_seen == i0 && bytes_seen == b0, "R10 no irq or byte", irq_seen - i0, 0);

        // S8: largest full-bit limit, very long idle gap (R3)
        lmax = 8'd255;
        b0 = bytes_seen; i0 = irq_seen;
        preamble_start(8); send_byte(8'h66, 1);
        hold(1'b0, 600);
        check(bytes_seen - b0 == 1, "R3 byte at max limit", bytes_seen - b0, 1);
        check(irq_seen - i0 == 1 && err_kind == 2'b01, "R3 saturating timeout", irq_seen - i0, 1);
        lmax = 8'd24;

        // S9: reset during receiving (R1)
        preamble_start(8);
        send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
        rst_n = 1'b0; @(negedge clk);
        check(mode == 2'b00 && err_kind == 2'b00, "R1 reset mid-frame", int'({mode, err_kind}), 0);
        check(!byte_valid && !err_irq, "R1 reset strobes", int'({byte_valid, err_irq}), 0);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        hold(rx_line, 40);
        check(exp_q.size() == 0, "R7 all bytes delivered", exp_q.size(), 0);
        finish_report();
    end

endmodule